// File: doc/BRIEF.md
# Condition-Flag Integer ALU

A purely combinational arithmetic unit for a small predicated RISC core. Each evaluation takes a 5-bit operation selector and two signed 32-bit operands, and returns a 32-bit result together with a 4-bit condition code. The condition code sorts the result into one of four classes: negative, zero, positive, or arithmetic fault. The core stores that code and tests later instructions against it.

The unit adds, subtracts, multiplies and divides. Division rounds toward negative infinity. The same adder forms effective addresses for memory reads and writes. A stop operation yields a constant zero. A zero divisor does not trap: it gives a zero result and the fault flag alone. Wrap-around on add, subtract and multiply goes unreported.

Top module: `cflag_alu`

## Requirements
- R1: Selector 3 returns the two's-complement sum of the operands, truncated to 32 bits.
- R2: Selector 5 returns the first operand minus the second, truncated to 32 bits.
- R3: Selector 6 returns the low 32 bits of the signed product.
- R4: Selector 7 with a nonzero divisor returns the floor quotient. For example, 12/-3 gives -4, 3/4 gives 0 and -7/2 gives -4. The case -2^31/-1 wraps to -2^31.
- R5: Selector 7 with a zero divisor returns result 0 and condition code 4'b1000, where bit 3 is the fault flag.
- R6: Selectors 1 and 2 return the operand sum, used as an address, and classify that sum like any other result.
- R7: Selector 0 returns 0 with condition code 4'b0010.
- R8: Selectors 4 and 8 through 31 return 0 with condition code 4'b0010.
- R9: For every non-faulting result exactly one flag is set: bit 0 when the result is negative, bit 1 when it is zero, bit 2 when it is positive.
- R10: The fault flag (bit 3) is never set by add, subtract, multiply, load or store, even when the true value does not fit in 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation selector |
| a_i | input | 32 | First signed operand |
| b_i | input | 32 | Second signed operand |
| result_o | output | 32 | Operation result |
| cond_o | output | 4 | Condition code {fault, positive, zero, negative} |

## Verification
Division gets the closest attention. The bench drives all four sign combinations, with and without a remainder. A design that truncated toward zero would return -3 instead of -4 for -7/2. A design that corrected the quotient when the remainder was zero would return -5 for 12/-3. The most negative dividend over -1 exposes a magnitude path that is too narrow. A zero divisor exposes a design that leaks the raw quotient, or that sets a sign flag next to the fault flag. Wrapping sums and products check that a design which raises the fault flag on overflow gets caught. Unused selectors 4, 8 and 31 show whether stray decode lets some datapath output through.

// File: rtl/cflag_alu_pkg.sv
package cflag_alu_pkg;
  localparam int OP_W   = 5;
  localparam int CC_W   = 4;
  localparam int CC_NEG = 0;
  localparam int CC_ZRO = 1;
  localparam int CC_POS = 2;
  localparam int CC_FLT = 3;

  typedef enum logic [OP_W-1:0] {
    OP_HALT  = 5'd0,
    OP_LOAD  = 5'd1,
    OP_STORE = 5'd2,
    OP_ADD   = 5'd3,
    OP_SUB   = 5'd5,
    OP_MUL   = 5'd6,
    OP_DIV   = 5'd7
  } op_e;
endpackage

// File: rtl/alu_floor_div.sv
module alu_floor_div #(
  parameter int W = 32
) (
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quot_o,
  output logic         div_zero_o
);
  logic         neg_a, neg_b, sign_diff;
  logic [W-1:0] mag_a, mag_b, mag_b_safe;
  logic [W-1:0] q_mag, r_mag, q_trunc;

  assign neg_a      = dividend_i[W-1];
  assign neg_b      = divisor_i[W-1];
  assign sign_diff  = neg_a ^ neg_b;
  // unsigned magnitudes: -2^(W-1) still fits
  assign mag_a      = neg_a ? (~dividend_i + 1'b1) : dividend_i;
  assign mag_b      = neg_b ? (~divisor_i + 1'b1) : divisor_i;
  assign div_zero_o = (divisor_i == '0);
  assign mag_b_safe = div_zero_o ? {{(W-1){1'b0}}, 1'b1} : mag_b;
  assign q_mag      = mag_a / mag_b_safe;
  assign r_mag      = mag_a % mag_b_safe;
  assign q_trunc    = sign_diff ? (~q_mag + 1'b1) : q_mag;

  always_comb begin
    if (div_zero_o)                       quot_o = '0;
    else if (sign_diff && (r_mag != '0))  quot_o = q_trunc - 1'b1;
    else                                  quot_o = q_trunc;
  end
endmodule

// File: rtl/alu_cond_gen.sv
module alu_cond_gen
  import cflag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]    value_i,
  input  logic            fault_i,
  output logic [CC_W-1:0] cond_o
);
  always_comb begin
    cond_o = '0;
    if (fault_i)              cond_o[CC_FLT] = 1'b1;
    else if (value_i[W-1])    cond_o[CC_NEG] = 1'b1;
    else if (value_i == '0)   cond_o[CC_ZRO] = 1'b1;
    else                      cond_o[CC_POS] = 1'b1;
  end
endmodule

// File: rtl/cflag_alu.sv
module cflag_alu
  import cflag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  output logic [W-1:0]    result_o,
  output logic [CC_W-1:0] cond_o
);
  logic [W-1:0] sum, diff, prod, quot;
  logic         div_zero, fault;

  assign sum  = a_i + b_i;
  assign diff = a_i - b_i;
  assign prod = a_i * b_i;  // low W bits match the signed product

  alu_floor_div #(.W(W)) u_div (
    .dividend_i (a_i),
    .divisor_i  (b_i),
    .quot_o     (quot),
    .div_zero_o (div_zero)
  );

  always_comb begin
    unique case (op_i)
      OP_LOAD, OP_STORE, OP_ADD: result_o = sum;
      OP_SUB:                    result_o = diff;
      OP_MUL:                    result_o = prod;
      OP_DIV:                    result_o = quot;
      default:                   result_o = '0;
    endcase
  end

  assign fault = (op_i == OP_DIV) && div_zero;

  alu_cond_gen #(.W(W)) u_cond (
    .value_i (result_o),
    .fault_i (fault),
    .cond_o  (cond_o)
  );
endmodule

// File: rtl/cflag_alu_chk.sv
module cflag_alu_chk
  import cflag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic [OP_W-1:0] op_i,
  input logic [W-1:0]    a_i,
  input logic [W-1:0]    b_i,
  input logic [W-1:0]    result_o,
  input logic [CC_W-1:0] cond_o
);
  logic known, is_div0, unused_op;
  assign known     = !$isunknown({op_i, a_i, b_i});
  assign is_div0   = (op_i == OP_DIV) && (b_i == '0);
  assign unused_op = (op_i == 5'd4) || (op_i > 5'd7);

  always_comb begin
    if (known) begin
      // R9
      cond_onehot_chk: assert ($countones(cond_o) == 1);
      // R9
      sign_class_chk: assert (cond_o[CC_FLT] ||
        (cond_o[CC_NEG] == result_o[W-1] && cond_o[CC_ZRO] == (result_o == '0)));
      // R10
      fault_only_div0_chk: assert (cond_o[CC_FLT] == is_div0);
      // R5
      div_zero_chk: assert (!is_div0 || (result_o == '0 && cond_o == 4'b1000));
      // R7
      halt_zero_chk: assert (op_i != OP_HALT || (result_o == '0 && cond_o == 4'b0010));
      // R8
      unused_op_chk: assert (!unused_op || (result_o == '0 && cond_o == 4'b0010));
    end
  end
endmodule

bind cflag_alu cflag_alu_chk #(.W(W)) u_chk (.*);

// File: tb/cflag_alu_test.sv
module cflag_alu_test;
  logic       clk;
  logic       rst_ni;
  logic [4:0] op_i;
  logic [31:0] a_i, b_i, result_o;
  logic [3:0] cond_o;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  cflag_alu uut (.op_i(op_i), .a_i(a_i), .b_i(b_i), .result_o(result_o), .cond_o(cond_o));

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [3:0] exp_cond(logic [31:0] v);
    if (v[31])      return 4'b0001;
    if (v == 32'd0) return 4'b0010;
    return 4'b0100;
  endfunction

  function automatic logic [31:0] exp_floor(logic [31:0] a, logic [31:0] b);
    longint sa, sb, q;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    q  = sa / sb;
    if ((sa % sb != 0) && ((sa < 0) != (sb < 0))) q = q - 1;
    return q[31:0];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [4:0] op, logic [31:0] a, logic [31:0] b);
    @(posedge clk);
    op_i = op; a_i = a; b_i = b;
    @(negedge clk);
  endtask

  task automatic run_vec(string req, logic [4:0] op, logic [31:0] a, logic [31:0] b,
                         logic [31:0] exp_r, logic [3:0] exp_c);
    apply(op, a, b);
    check(req, result_o, exp_r);
    check(req, {28'd0, cond_o}, {28'd0, exp_c});
  endtask

  task automatic test_reset;
    @(negedge clk);
    check("R7 reset", result_o, 32'd0);
    check("R7 reset", {28'd0, cond_o}, 32'd2);
  endtask

  task automatic test_add;  // R1 R9 R10
    run_vec("R1", 5'd3, 32'd5, 32'd3, 32'd8, 4'b0100);
    run_vec("R1", 5'd3, -32'sd5, 32'd3, -32'sd2, 4'b0001);
    run_vec("R9", 5'd3, -32'sd10, 32'd10, 32'd0, 4'b0010);
    run_vec("R10", 5'd3, 32'h7fff_ffff, 32'd1, 32'h8000_0000, 4'b0001);
  endtask

  task automatic test_sub;  // R2
    run_vec("R2", 5'd5, 32'd5, 32'd3, 32'd2, 4'b0100);
    run_vec("R2", 5'd5, 32'd3, 32'd5, -32'sd2, 4'b0001);
    run_vec("R2", 5'd5, 32'd3, 32'd3, 32'd0, 4'b0010);
    run_vec("R10", 5'd5, 32'h8000_0000, 32'd1, 32'h7fff_ffff, 4'b0100);
  endtask

  task automatic test_mul;  // R3
    run_vec("R3", 5'd6, 32'd3, 32'd5, 32'd15, 4'b0100);
    run_vec("R3", 5'd6, -32'sd3, 32'd5, -32'sd15, 4'b0001);
    run_vec("R3", 5'd6, 32'd0, 32'd22, 32'd0, 4'b0010);
    run_vec("R10", 5'd6, 32'h0001_0000, 32'h0001_0001, 32'h0001_0000, 4'b0100);
  endtask

  task automatic test_div;  // R4
    logic [31:0] q;
    logic [31:0] va [8] = '{32'd5, 32'd12, 32'd3, -32'sd7, 32'd7, -32'sd7, -32'sd12, 32'h8000_0000};
    logic [31:0] vb [8] = '{32'd3, -32'sd3, 32'd4, 32'd2, -32'sd2, -32'sd2, -32'sd5, 32'hffff_ffff};
    for (int i = 0; i < 8; i++) begin
      q = exp_floor(va[i], vb[i]);
      run_vec("R4", 5'd7, va[i], vb[i], q, exp_cond(q));
    end
    run_vec("R4 12/-3", 5'd7, 32'd12, -32'sd3, -32'sd4, 4'b0001);
    run_vec("R4 -7/2", 5'd7, -32'sd7, 32'd2, -32'sd4, 4'b0001);
  endtask

  task automatic test_div_zero;  // R5
    run_vec("R5", 5'd7, 32'd12, 32'd0, 32'd0, 4'b1000);
    run_vec("R5", 5'd7, -32'sd9, 32'd0, 32'd0, 4'b1000);
  endtask

  task automatic test_mem;  // R6
    run_vec("R6 load", 5'd1, 32'd12, 32'd13, 32'd25, 4'b0100);
    run_vec("R6 store", 5'd2, 32'd27, 32'd13, 32'd40, 4'b0100);
    run_vec("R6 load", 5'd1, 32'd4, -32'sd4, 32'd0, 4'b0010);
    run_vec("R6 store", 5'd2, 32'd1, -32'sd9, -32'sd8, 4'b0001);
  endtask

  task automatic test_halt;  // R7
    run_vec("R7", 5'd0, 32'd99, 32'd98, 32'd0, 4'b0010);
  endtask

  task automatic test_unused;  // R8
    run_vec("R8", 5'd4, 32'd5, 32'd6, 32'd0, 4'b0010);
    run_vec("R8", 5'd8, -32'sd5, 32'd6, 32'd0, 4'b0010);
    run_vec("R8", 5'd31, 32'd7, 32'd0, 32'd0, 4'b0010);
  endtask

  initial begin
    rst_ni = 0;
    op_i = 5'd0; a_i = 32'd0; b_i = 32'd0;
    repeat (2) @(posedge clk);
    rst_ni = 1;
    test_reset();
    test_add();
    test_sub();
    test_mul();
    test_div();
    test_div_zero();
    test_mem();
    test_halt();
    test_unused();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule